// File: doc/BRIEF.md
# Crystal Stabilization Status and Oscillator Stop Guard

This block sits beside the main crystal oscillator of a clock subsystem. It keeps an 8-bit stabilization status byte that shows how long the crystal has been running since its last start. The byte is a thermometer code. Each bit, working down from the top bit, sets once the cycle count passes its threshold, and it stays set. Counting restarts from zero on either of two events. The first is the crystal being switched on in oscillator mode. The second is the release of the low-power stop state while the main oscillator is enabled. Software can poll the whole byte or test a single bit to decide when the crystal can be trusted as the CPU clock.

The block also holds the stop flags of three clock sources: main, sub and internal high-speed. It checks every request to set a stop flag against the CPU clock source that is currently selected. That source is decoded from two select bits, `cpu_sub_sel` and `cpu_main_sel`. A request that would stop the clock the CPU is running on is refused and latches a sticky error. Accepted and refused writes both take effect at the next clock edge. The flags drive the per-oscillator enable outputs directly.

Top module: `osc_stab_ctrl`

## Requirements
- R1: After a synchronous reset, `stab_status` is 00h, `stab_done` is 0, `stop_err` is 0, `main_en` is 0, `sub_en` is 0 and `hio_en` is 1.
- R2: A cycle with `stop_enter`=1, or with an accepted write of 1 to the main stop flag, makes `stab_status` 00h after that edge and halts counting. A clear wins over a start in the same cycle.
- R3: A write of 0 to the main stop flag while it is set, with `xt_ext_sel`=0 and `xt_osc_mode`=1, starts the count at zero. The same write with `xt_ext_sel`=1 sets `main_en` but leaves `stab_status` at 00h.
- R4: `stop_release` after `stop_enter` restarts the count at zero when `main_en`=1. When `main_en`=0 the status stays 00h.
- R5: N edges after the edge that samples a start, bit 7-j of `stab_status` is 1 exactly when N >= 2^e. Here e = BASE_EXP for j=0 and e = BASE_EXP+1+j for j=1..7.
- R6: The count saturates at 2^(BASE_EXP+8). `stab_done` is 1 for the single cycle after the edge on which the count reaches that value. After that, `stab_status` holds FFh.
- R7: A write of 1 to the main stop flag is accepted only when `cpu_sub_sel`=1, or when `cpu_sub_sel`=0 and `cpu_main_sel`=0.
- R8: A write of 1 to the sub stop flag is accepted only when `cpu_sub_sel`=0.
- R9: A write of 1 to the internal high-speed stop flag is accepted only when `cpu_sub_sel`=1, or when `cpu_sub_sel`=0 and `cpu_main_sel`=1.
- R10: A refused write leaves its flag and enable unchanged and sets `stop_err`, which stays 1 until reset. A write of 0 is always accepted. Each enable is the inverse of its stop flag and updates on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xt_ext_sel | input | 1 | 1 = external clock input instead of crystal |
| xt_osc_mode | input | 1 | 1 = main pins in oscillator mode |
| cpu_sub_sel | input | 1 | CPU clock status: 1 = sub clock |
| cpu_main_sel | input | 1 | CPU clock status when not sub: 1 = main, 0 = internal |
| main_stop_wr | input | 1 | Write strobe for main stop flag |
| main_stop_val | input | 1 | Value written to main stop flag |
| sub_stop_wr | input | 1 | Write strobe for sub stop flag |
| sub_stop_val | input | 1 | Value written to sub stop flag |
| hio_stop_wr | input | 1 | Write strobe for internal high-speed stop flag |
| hio_stop_val | input | 1 | Value written to internal high-speed stop flag |
| stop_enter | input | 1 | Pulse: stop state entered |
| stop_release | input | 1 | Pulse: stop state released |
| stab_status | output | 8 | Thermometer stabilization status |
| stab_done | output | 1 | One-cycle pulse at count saturation |
| main_en | output | 1 | Main oscillator enable |
| sub_en | output | 1 | Sub oscillator enable |
| hio_en | output | 1 | Internal high-speed oscillator enable |
| stop_err | output | 1 | Sticky refused-stop error |

## Verification
A count that is off by one moves the rise of each status bit by one cycle, and the shift is visible at the first threshold. A counter that wraps instead of saturating drops bits on the cycle after 2^(BASE_EXP+8), and `stab_done` then fires again. A clear that loses to a start leaves nonzero status a few cycles after a stop entry. A wrong source decode shows up on the next edge, as a wrong enable value or a wrong `stop_err` in the sweep over all four select combinations.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned N_OSC  = 3;
  localparam int unsigned IDX_MAIN = 0;
  localparam int unsigned IDX_SUB  = 1;
  localparam int unsigned IDX_HIO  = 2;

  typedef enum logic [1:0] {
    SRC_HIO  = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_SUB  = 2'd2
  } clk_src_e;

  function automatic clk_src_e decode_src(input logic sub_sel, input logic main_sel);
    if (sub_sel)       return SRC_SUB;
    else if (main_sel) return SRC_MAIN;
    else               return SRC_HIO;
  endfunction

  // exponent of the threshold for tap j (j=0 is the top status bit)
  function automatic int unsigned tap_exp(input int unsigned base, input int unsigned j);
    if (j == 0) return base;
    else        return base + 1 + j;
  endfunction
endpackage

// File: rtl/osc_stop_guard.sv
module osc_stop_guard
  import osc_stab_pkg::*;
#(
  parameter logic [N_OSC-1:0] RST_STOP = 3'b011
) (
  input  logic             clk,
  input  logic             rst,
  input  clk_src_e         src,
  input  logic [N_OSC-1:0] wr,
  input  logic [N_OSC-1:0] val,
  output logic [N_OSC-1:0] stop_q,
  output logic             err_q,
  output logic [N_OSC-1:0] set_ok,
  output logic [N_OSC-1:0] clr_go
);
  logic [N_OSC-1:0] busy;
  logic [N_OSC-1:0] refuse;

  always_comb begin
    busy           = '0;
    busy[IDX_MAIN] = (src == SRC_MAIN);
    busy[IDX_SUB]  = (src == SRC_SUB);
    busy[IDX_HIO]  = (src == SRC_HIO);
  end

  for (genvar i = 0; i < N_OSC; i++) begin : g_osc
    assign set_ok[i] = wr[i] & val[i] & ~busy[i];
    assign refuse[i] = wr[i] & val[i] & busy[i];
    assign clr_go[i] = wr[i] & ~val[i] & stop_q[i];

    always_ff @(posedge clk) begin
      if (rst)                 stop_q[i] <= RST_STOP[i];
      else if (set_ok[i])      stop_q[i] <= 1'b1;
      else if (wr[i] & ~val[i]) stop_q[i] <= 1'b0;
    end

    // R10: a refused request leaves the flag as it was
    p_refuse_keeps_flag_r10: assert property (@(posedge clk) disable iff (rst)
      refuse[i] |=> stop_q[i] == $past(stop_q[i]));
  end

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (|refuse) err_q <= 1'b1;
  end

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  p_err_on_refuse_r10: assert property (@(posedge clk) disable iff (rst)
    (|refuse) |=> err_q);
endmodule

// File: rtl/osc_stab_counter.sv
module osc_stab_counter #(
  parameter int unsigned BASE_EXP = 11,
  localparam int unsigned CW = BASE_EXP + 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  output logic [CW-1:0] cnt_d,
  output logic [CW-1:0] cnt_q,
  output logic          done_q
);
  localparam logic [CW-1:0] TOP = {{(CW-1){1'b0}}, 1'b1} << (BASE_EXP + 8);

  logic run_q, run_d, hit;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    hit   = 1'b0;
    if (clr) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == TOP - 1'b1) begin
        run_d = 1'b0;
        hit   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= hit;
    end
  end

  p_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  p_start_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !clr) |=> cnt_q == '0 && run_q);
  p_clear_halts_r2: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt_q == '0 && !run_q);
endmodule

// File: rtl/osc_stab_status.sv
module osc_stab_status
  import osc_stab_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11,
  localparam int unsigned CW = BASE_EXP + 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_next,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] tap;

  for (genvar b = 0; b < STAT_W; b++) begin : g_tap
    localparam int unsigned E = tap_exp(BASE_EXP, STAT_W - 1 - b);
    localparam logic [CW-1:0] THR = {{(CW-1){1'b0}}, 1'b1} << E;
    assign tap[b] = (cnt_next >= THR);
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= tap;
  end

  // R5: a set bit implies every bit above it is set
  p_thermo_shape_r5: assert property (@(posedge clk) disable iff (rst)
    (((status_q << 1) & ~status_q) == '0));
endmodule

// File: rtl/osc_stab_ctrl.sv
module osc_stab_ctrl
  import osc_stab_pkg::*;
#(
  parameter int unsigned BASE_EXP = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xt_ext_sel,
  input  logic       xt_osc_mode,
  input  logic       cpu_sub_sel,
  input  logic       cpu_main_sel,
  input  logic       main_stop_wr,
  input  logic       main_stop_val,
  input  logic       sub_stop_wr,
  input  logic       sub_stop_val,
  input  logic       hio_stop_wr,
  input  logic       hio_stop_val,
  input  logic       stop_enter,
  input  logic       stop_release,
  output logic [7:0] stab_status,
  output logic       stab_done,
  output logic       main_en,
  output logic       sub_en,
  output logic       hio_en,
  output logic       stop_err
);
  localparam int unsigned CW = BASE_EXP + 9;

  clk_src_e         src;
  logic [N_OSC-1:0] wr, val, stop_q, set_ok, clr_go;
  logic             in_stop_q, clr, start, xt_go;
  logic [CW-1:0]    cnt_d, cnt_q;

  assign src = decode_src(cpu_sub_sel, cpu_main_sel);

  always_comb begin
    wr            = '0;
    val           = '0;
    wr[IDX_MAIN]  = main_stop_wr;
    val[IDX_MAIN] = main_stop_val;
    wr[IDX_SUB]   = sub_stop_wr;
    val[IDX_SUB]  = sub_stop_val;
    wr[IDX_HIO]   = hio_stop_wr;
    val[IDX_HIO]  = hio_stop_val;
  end

  osc_stop_guard #(.RST_STOP(3'b011)) u_guard (
    .clk(clk), .rst(rst), .src(src), .wr(wr), .val(val),
    .stop_q(stop_q), .err_q(stop_err), .set_ok(set_ok), .clr_go(clr_go)
  );

  always_ff @(posedge clk) begin
    if (rst)               in_stop_q <= 1'b0;
    else if (stop_enter)   in_stop_q <= 1'b1;
    else if (stop_release) in_stop_q <= 1'b0;
  end

  assign xt_go = clr_go[IDX_MAIN] & ~xt_ext_sel & xt_osc_mode;
  assign clr   = stop_enter | set_ok[IDX_MAIN];
  assign start = xt_go | (stop_release & in_stop_q & ~stop_q[IDX_MAIN]);

  osc_stab_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .start(start),
    .cnt_d(cnt_d), .cnt_q(cnt_q), .done_q(stab_done)
  );

  osc_stab_status #(.BASE_EXP(BASE_EXP)) u_stat (
    .clk(clk), .rst(rst), .cnt_next(cnt_d), .status_q(stab_status)
  );

  assign main_en = ~stop_q[IDX_MAIN];
  assign sub_en  = ~stop_q[IDX_SUB];
  assign hio_en  = ~stop_q[IDX_HIO];

  p_clear_on_enter_r2: assert property (@(posedge clk) disable iff (rst)
    stop_enter |=> stab_status == 8'h00);
  p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
    stab_done |-> stab_status == 8'hFF);
  p_main_guard_r7: assert property (@(posedge clk) disable iff (rst)
    (main_stop_wr && main_stop_val && !cpu_sub_sel && cpu_main_sel) |=> stop_err);
  p_sub_guard_r8: assert property (@(posedge clk) disable iff (rst)
    (sub_stop_wr && sub_stop_val && !cpu_sub_sel) |=> !sub_en);
  p_hio_guard_r9: assert property (@(posedge clk) disable iff (rst)
    (hio_stop_wr && hio_stop_val && (cpu_sub_sel || cpu_main_sel)) |=> !hio_en);
endmodule

// File: tb/tb_osc_stab_ctrl.sv
module tb_osc_stab_ctrl;
  localparam int CLK_P = 10;
  localparam int B = 2;
  localparam int TOP = 1 << (B + 8);

  logic clk = 0, rst = 1;
  logic xt_ext_sel = 0, xt_osc_mode = 1, cpu_sub_sel = 0, cpu_main_sel = 0;
  logic main_stop_wr = 0, main_stop_val = 0, sub_stop_wr = 0, sub_stop_val = 0;
  logic hio_stop_wr = 0, hio_stop_val = 0, stop_enter = 0, stop_release = 0;
  logic [7:0] stab_status;
  logic stab_done, main_en, sub_en, hio_en, stop_err;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  osc_stab_ctrl #(.BASE_EXP(B)) dut (.*);

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] therm(int n);
    logic [7:0] r = '0;
    for (int j = 0; j < 8; j++) begin
      int e = (j == 0) ? B : B + 1 + j;
      r[7-j] = (n >= (1 << e));
    end
    return r;
  endfunction

  task automatic do_reset();
    rst = 1; tick(2); rst = 0;
  endtask

  task automatic wr_main(logic v); main_stop_wr = 1; main_stop_val = v; tick(); main_stop_wr = 0; endtask
  task automatic wr_sub(logic v);  sub_stop_wr = 1;  sub_stop_val = v;  tick(); sub_stop_wr = 0;  endtask
  task automatic wr_hio(logic v);  hio_stop_wr = 1;  hio_stop_val = v;  tick(); hio_stop_wr = 0;  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    do_reset();
    // R1 reset state
    chk("R1 status", stab_status, 8'h00);
    chk("R1 done", stab_done, 0);
    chk("R1 err", stop_err, 0);
    chk("R1 main_en", main_en, 0);
    chk("R1 sub_en", sub_en, 0);
    chk("R1 hio_en", hio_en, 1);

    // R3 + R5 + R6: crystal start, full sweep of the count
    xt_ext_sel = 0; xt_osc_mode = 1;
    wr_main(0);
    chk("R3 start zero", stab_status, 8'h00);
    chk("R10 main_en", main_en, 1);
    for (int n = 1; n <= TOP + 8; n++) begin
      tick();
      chk("R5 thermometer", stab_status, therm(n));
      chk("R6 done pulse", stab_done, (n == TOP));
    end

    // R2: stop entry clears mid-count; R4 release restarts
    stop_enter = 1; tick(); stop_enter = 0;
    chk("R2 clear on stop entry", stab_status, 8'h00);
    tick(40);
    chk("R2 halted", stab_status, 8'h00);
    stop_release = 1; tick(); stop_release = 0;
    tick(1 << B);
    chk("R4 restart after release", stab_status, therm(1 << B));
    tick(60);
    chk("R4 count continues", stab_status, therm((1 << B) + 60));

    // R2: accepted main stop set clears (CPU on internal clock)
    cpu_sub_sel = 0; cpu_main_sel = 0;
    wr_main(1);
    chk("R2 clear on main stop", stab_status, 8'h00);
    chk("R7 main stopped", main_en, 0);
    tick(20);
    chk("R2 stays clear", stab_status, 8'h00);

    // R4: release with main stopped does not restart
    stop_enter = 1; tick(); stop_enter = 0;
    stop_release = 1; tick(); stop_release = 0;
    tick(30);
    chk("R4 no restart when main off", stab_status, 8'h00);

    // R2: clear beats start in the same cycle
    main_stop_wr = 1; main_stop_val = 0; stop_enter = 1; tick();
    main_stop_wr = 0; stop_enter = 0;
    tick(30);
    chk("R2 clear wins over start", stab_status, 8'h00);

    // R3: external clock mode enables main but does not count
    do_reset();
    xt_ext_sel = 1;
    wr_main(0);
    tick(30);
    chk("R3 ext sel main_en", main_en, 1);
    chk("R3 ext sel no count", stab_status, 8'h00);
    xt_ext_sel = 0;

    // R7 R8 R9 R10: sweep of the clock-select decode
    for (int c = 0; c < 4; c++) begin
      logic cls, mcs, ok_m, ok_s, ok_h, exp_err;
      cls = c[1]; mcs = c[0];
      ok_m = cls | ~mcs; ok_s = ~cls; ok_h = cls | mcs;
      do_reset();
      xt_ext_sel = 1;
      cpu_sub_sel = cls; cpu_main_sel = mcs;
      wr_main(0); wr_sub(0);
      chk("R10 clear accepted main", main_en, 1);
      chk("R10 clear accepted sub", sub_en, 1);
      exp_err = 0;
      wr_main(1);
      chk("R7 main guard", main_en, !ok_m);
      exp_err |= !ok_m;
      chk("R10 err after main", stop_err, exp_err);
      wr_main(0);
      wr_sub(1);
      chk("R8 sub guard", sub_en, !ok_s);
      exp_err |= !ok_s;
      chk("R10 err after sub", stop_err, exp_err);
      wr_sub(0);
      wr_hio(1);
      chk("R9 hio guard", hio_en, !ok_h);
      exp_err |= !ok_h;
      chk("R10 err after hio", stop_err, exp_err);
      wr_hio(0);
      tick(3);
      chk("R10 err sticky", stop_err, exp_err);
      chk("R10 hio reenabled", hio_en, 1);
    end
    xt_ext_sel = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule